// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block turns eight pins that normally carry the parallel host data bus into a general-purpose I/O port. It does so only while the device is strapped for the serial two-wire host interface, because only then are those pins free. Software reaches the port through a small register read/write port. A direction register picks, bit by bit, whether a pin drives or listens. A single data register holds the values that output pins drive, and it also receives the sampled levels of the pins configured as inputs.

Pad inputs are passed through a two-flop synchronizer before they land in the data register. A software write to the data register changes only the bits configured as outputs, so sampled input bits are never overwritten. In parallel host mode every output enable is held low and input sampling stops. Both registers can still be written in that mode.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset, the direction register reads 0x00 (all pins inputs) and the data register reads 0x00.
- R2: When `serial_mode` is 1, `pad_oe` equals the direction register. When `serial_mode` is 0, `pad_oe` is all zeros.
- R3: `pad_out` always equals the data register, bit for bit.
- R4: A write (`wr_en`=1) to address 0x09 loads the direction register with `wr_data` at that rising edge. A direction bit of 1 means output and 0 means input.
- R5: A write to address 0x0A loads `wr_data` only into data bits whose direction bit is 1. The written value has no effect on bits whose direction bit is 0.
- R6: In serial mode, a change on an input-direction pad first shows in the data register after the third rising edge following the change (two synchronizer stages, then the latch).
- R7: In parallel mode (`serial_mode`=0), input-direction data bits hold their value whatever the pads do.
- R8: `rd_data` is combinational on `addr`: 0x09 returns the direction register, 0x0A returns the data register, and any other address returns 0x00.
- R9: Output-direction data bits ignore the pad inputs and change only through writes to 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | 1 = serial host mode selected, so the port is active |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Per-pin output enables |

## Verification
On every cycle, the assertions check four things. Output enables stay off in parallel mode. Output bits move only on a data write, and then to the written value. Input bits follow the synchronizer's last stage in serial mode and freeze in parallel mode. Direction writes land in the direction register. Only the bench scenarios can show the rest: the reset values, the exact three-edge latency from pad to register, the read decoding of unused addresses, and the combined result of writing a value while inputs are sampled. The bench checks that combined result by sweeping all 256 direction patterns with the expected data computed as a mask merge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W  = 8;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] DIR_ADDR  = 4'h9;
  localparam logic [ADDR_W-1:0] DATA_ADDR = 4'hA;

  // Next data register value: output bits take the write (if any), input bits
  // take the synchronized pad value while the port is active.
  function automatic logic [PORT_W-1:0] next_data(
    input logic [PORT_W-1:0] cur,
    input logic [PORT_W-1:0] dir,
    input logic [PORT_W-1:0] wval,
    input logic              wr_hit,
    input logic [PORT_W-1:0] sampled,
    input logic              active);
    logic [PORT_W-1:0] outs, ins;
    outs = wr_hit ? wval : cur;
    ins  = active ? sampled : cur;
    return (outs & dir) | (ins & ~dir);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] sampled,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] data_q,
  output logic              dir_wr,
  output logic              data_wr
);
  assign dir_wr  = wr_en && (addr == DIR_ADDR);
  assign data_wr = wr_en && (addr == DATA_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) data_q <= '0;
    else        data_q <= next_data(data_q, dir_q, wr_data, data_wr, sampled, active);
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
  import gpio_pkg::*;
(
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] rd_data
);
  assign pad_oe  = active ? dir_q : '0;
  assign pad_out = data_q;

  always_comb begin
    case (addr)
      DIR_ADDR:  rd_data = dir_q;
      DATA_ADDR: rd_data = data_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  logic [PORT_W-1:0] sync_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] data_q;
  logic              dir_wr;
  logic              data_wr;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q));

  gpio_regs regs_i (
    .clk(clk), .rst_n(rst_n), .active(serial_mode), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .sampled(sync_q),
    .dir_q(dir_q), .data_q(data_q), .dir_wr(dir_wr), .data_wr(data_wr));

  gpio_padctl pad_i (
    .active(serial_mode), .addr(addr), .dir_q(dir_q), .data_q(data_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .rd_data(rd_data));
endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk
  import gpio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              serial_mode,
  input logic [PORT_W-1:0] wr_data,
  input logic [PORT_W-1:0] pad_oe,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] sync_q,
  input logic [PORT_W-1:0] dir_q,
  input logic              dir_wr,
  input logic              data_wr
);
  a_r2_oe_off_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_mode |-> pad_oe == '0);

  a_r9_out_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> ((pad_out ^ $past(pad_out)) & $past(dir_q)) == '0);

  a_r5_write_out_bits: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((pad_out ^ $past(wr_data)) & $past(dir_q)) == '0);

  a_r6_input_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    serial_mode |=> ((pad_out ^ $past(sync_q)) & ~$past(dir_q)) == '0);

  a_r7_input_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_mode |=> ((pad_out ^ $past(pad_out)) & ~$past(dir_q)) == '0);

  a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> dir_q == $past(wr_data));
endmodule

bind gpio_shared_port gpio_shared_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .wr_data(wr_data),
  .pad_oe(pad_oe), .pad_out(pad_out), .sync_q(sync_q), .dir_q(dir_q),
  .dir_wr(dir_wr), .data_wr(data_wr));

// File: tb/gpio_shared_port_tb_top.sv
module gpio_shared_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       serial_mode = 1;
  logic [3:0] addr = 4'h0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_shared_port dut_i (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; each call advances one rising edge.
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] p, w, hold;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(4'h9, v); check("R1 dir reset", v, 8'h00);
    rd(4'hA, v); check("R1 data reset", v, 8'h00);
    rst_n = 1;
    tick();

    // R8 unused addresses read zero
    wr(4'h9, 8'hFF); wr(4'hA, 8'hA5);
    for (int a = 0; a < 16; a++) begin
      if (a != 9 && a != 10) begin
        rd(a[3:0], v); check("R8 unused addr", v, 8'h00);
      end
    end
    rd(4'h9, v); check("R8 dir read", v, 8'hFF);
    rd(4'hA, v); check("R8 data read", v, 8'hA5);

    // R6 latency: dir all inputs, step pads 00 -> FF
    wr(4'h9, 8'h00);
    pad_in = 8'h00; tick(); tick(); tick();
    pad_in = 8'hFF;
    tick(); rd(4'hA, v); check("R6 edge1 not yet", v, 8'h00);
    tick(); rd(4'hA, v); check("R6 edge2 not yet", v, 8'h00);
    tick(); rd(4'hA, v); check("R6 edge3 latched", v, 8'hFF);

    // Sweep all direction patterns: R2 R3 R4 R5 R6
    for (int d = 0; d < 256; d++) begin
      p = d[7:0] ^ {d[2:0], d[7:3]} ^ 8'h5A;
      w = ~p;
      pad_in = p;
      wr(4'h9, d[7:0]);
      wr(4'hA, w);
      tick(); tick();
      rd(4'h9, v); check("R4 dir write", v, d[7:0]);
      rd(4'hA, v); check("R5 R6 data merge", v, (w & d[7:0]) | (p & ~d[7:0]));
      check("R3 pad_out mirrors data", pad_out, (w & d[7:0]) | (p & ~d[7:0]));
      check("R2 oe serial", pad_oe, d[7:0]);
    end

    // R9: output bits ignore pads
    wr(4'h9, 8'hFF); wr(4'hA, 8'h3C);
    for (int k = 0; k < 8; k++) begin
      pad_in = 8'h01 << k;
      tick(); tick(); tick();
      check("R9 outputs ignore pads", pad_out, 8'h3C);
    end

    // R5: write has no effect on input bits
    wr(4'h9, 8'h0F); pad_in = 8'h50; tick(); tick(); tick();
    wr(4'hA, 8'hAF);
    rd(4'hA, v); check("R5 input bits keep sample", v, 8'h5F);

    // R7 / R2 parallel mode
    wr(4'h9, 8'h00); pad_in = 8'hC3; tick(); tick(); tick();
    rd(4'hA, hold); check("R6 settle before parallel", hold, 8'hC3);
    serial_mode = 0;
    #1; check("R2 oe off parallel", pad_oe, 8'h00);
    for (int k = 0; k < 4; k++) begin
      pad_in = 8'h11 * k[7:0];
      tick(); tick(); tick();
      rd(4'hA, v); check("R7 inputs frozen", v, hold);
    end
    wr(4'h9, 8'hF0);
    #1; check("R2 oe off with outputs", pad_oe, 8'h00);
    wr(4'hA, 8'h5A);
    rd(4'hA, v); check("R5 write in parallel", v, 8'h50 | (hold & 8'h0F));
    serial_mode = 1;
    #1; check("R2 oe back on", pad_oe, 8'hF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule